// File: doc/BRIEF.md
# Dual-Link Pixel Splitter and Lane Router

This block sits between a display timing source and one or two serial link formatters. It accepts one parallel pixel per clock, together with horizontal sync, vertical sync and a display-enable, and produces two output ports: a primary link and a companion link. Each output carries a valid strobe, a pixel word and four control slots. In single-link operation every active pixel goes straight to the primary link one cycle after it arrives, and the companion link stays quiet.

In dual-link operation the pixels of each line are paired. The first active pixel of every line has index 0, so it is even. Each even pixel is held until its odd neighbour arrives. Both links then update together in the same cycle, one pixel each. A mode value picks which link carries the even pixels. A line with an odd number of pixels is closed by a final pair whose odd half is zero.

The pixel word is divided into four data lanes. A lane-exchange input swaps lanes 1 and 3 on both outputs, for boards that route those lanes crossed. The sync and enable signals are placed into fixed control slots on every link that is in use. All configuration inputs are static. They may change only while the block is in reset or while display-enable is low.

Top module: `pix_link_splitter`

## Requirements
- R1: `link_mode_i` selects the routing. 0 is single link, 1 is dual link with even pixels on the primary link, 2 is dual link with odd pixels on the primary link, and 3 behaves exactly like 0.
- R2: In single-link routing, a pixel sampled with `de_i` high appears on `pri_data_o` with `pri_valid_o` high on the next cycle. `cmp_valid_o`, `cmp_data_o` and `cmp_ctrl_o` stay zero.
- R3: In dual-link routing, the pixel index restarts at 0 on the first cycle `de_i` is high after a low cycle. After each odd-indexed pixel is sampled, `pri_valid_o` and `cmp_valid_o` are both high for exactly one cycle, on the following cycle, and they are never high on two cycles in a row.
- R4: With mode 1, each pair puts the even pixel on `pri_data_o` and the odd pixel on `cmp_data_o`.
- R5: With mode 2, each pair puts the odd pixel on `pri_data_o` and the even pixel on `cmp_data_o`.
- R6: In dual-link routing, if `de_i` falls while an even pixel is unpaired, the next cycle emits a pair whose odd half is all zeros. The halves are placed on the links as in R4 or R5.
- R7: Control slot bits are registered one cycle: bit 0 carries hsync, bit 1 carries vsync, bit 2 carries display-enable, and bit 3 is zero. They appear on `pri_ctrl_o` always, and on `cmp_ctrl_o` only in dual-link routing.
- R8: Lane k of a pixel word occupies bits [k*LANE_W +: LANE_W]. With `lane_swap_i` low, lanes pass straight through. With it high, output lane 1 takes input lane 3, output lane 3 takes input lane 1, and lanes 0 and 2 are unchanged. This applies to both links.
- R9: When a link's valid is low and its registered enable slot (bit 2) is low, its data is zero. In dual-link routing, while enable is high, data holds the last pair between strobes.
- R10: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_mode_i | input | 2 | Routing mode (R1) |
| lane_swap_i | input | 1 | Exchange lanes 1 and 3 |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Display enable, high on active pixels |
| pix_i | input | 4*LANE_W | Input pixel, four lanes |
| pri_valid_o | output | 1 | Primary link pixel strobe |
| pri_data_o | output | 4*LANE_W | Primary link pixel |
| pri_ctrl_o | output | 4 | Primary link control slots |
| cmp_valid_o | output | 1 | Companion link pixel strobe |
| cmp_data_o | output | 4*LANE_W | Companion link pixel |
| cmp_ctrl_o | output | 4 | Companion link control slots |

## Verification
The bench builds the block with LANE_W set to 5. This gives a 20-bit pixel in which each lane holds a distinct small value. With that setting, a lane exchange or a lane landing in the wrong field shows up as a specific wrong number, not just a mismatch somewhere in the word.

Short directed lines cover several cases in every routing mode:
- even-length lines, where pairs complete normally;
- odd-length lines, where the trailing pixel is flushed with a zero partner;
- a line that starts right after a flush, to confirm the index restarts.

These short lines reach the hold-between-strobes behaviour and the zeroing during blanking within a few cycles.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned NUM_SLOTS = 4;

  typedef enum logic [1:0] {
    LINK_SINGLE    = 2'd0,
    LINK_DUAL_EVEN = 2'd1,
    LINK_DUAL_ODD  = 2'd2,
    LINK_RSVD      = 2'd3
  } link_mode_e;

  localparam int unsigned SLOT_HS = 0;
  localparam int unsigned SLOT_VS = 1;
  localparam int unsigned SLOT_DE = 2;
  localparam int unsigned SLOT_Z  = 3;
endpackage

// File: rtl/lane_router.sv
module lane_router
  import lsplit_pkg::*;
#(
  parameter int unsigned LANE_W = 7,
  localparam int unsigned PIX_W = NUM_LANES * LANE_W
) (
  input  logic             swap_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] pix_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int unsigned SRC = (k == 1) ? 3 : ((k == 3) ? 1 : k);
    assign pix_o[k*LANE_W +: LANE_W] = swap_i ? pix_i[SRC*LANE_W +: LANE_W]
                                              : pix_i[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ctrl_mapper.sv
module ctrl_mapper
  import lsplit_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dual_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  output logic [NUM_SLOTS-1:0] pri_ctrl_o,
  output logic [NUM_SLOTS-1:0] cmp_ctrl_o
);
  logic [NUM_SLOTS-1:0] slots;

  always_comb begin
    slots          = '0;
    slots[SLOT_HS] = hsync_i;
    slots[SLOT_VS] = vsync_i;
    slots[SLOT_DE] = de_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_ctrl_o <= '0;
      cmp_ctrl_o <= '0;
    end else begin
      pri_ctrl_o <= slots;
      cmp_ctrl_o <= dual_i ? slots : '0;
    end
  end

  assert_slot_map_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pri_ctrl_o[0] == $past(hsync_i)) && (pri_ctrl_o[1] == $past(vsync_i))
             && (pri_ctrl_o[2] == $past(de_i)) && !pri_ctrl_o[3]);

  assert_cmp_ctrl_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_i |=> cmp_ctrl_o == '0);
endmodule

// File: rtl/pair_splitter.sv
module pair_splitter #(
  parameter int unsigned PIX_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dual_i,
  input  logic             odd_first_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             pri_valid_o,
  output logic [PIX_W-1:0] pri_data_o,
  output logic             cmp_valid_o,
  output logic [PIX_W-1:0] cmp_data_o
);
  logic             de_q;
  logic             have_even_q;
  logic [PIX_W-1:0] even_q;
  logic             line_start;
  logic             emit;
  logic [PIX_W-1:0] odd_pix;

  assign line_start = de_i && !de_q;
  // pair completes on an odd pixel, or flushes a dangling even pixel at line end
  assign emit    = dual_i && have_even_q && (de_i ? !line_start : 1'b1);
  assign odd_pix = de_i ? pix_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q        <= 1'b0;
      have_even_q <= 1'b0;
      even_q      <= '0;
    end else begin
      de_q <= de_i;
      if (!dual_i) begin
        have_even_q <= 1'b0;
      end else if (de_i && (line_start || !have_even_q)) begin
        have_even_q <= 1'b1;
        even_q      <= pix_i;
      end else if (emit) begin
        have_even_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_valid_o <= 1'b0;
      cmp_valid_o <= 1'b0;
      pri_data_o  <= '0;
      cmp_data_o  <= '0;
    end else if (!dual_i) begin
      pri_valid_o <= de_i;
      pri_data_o  <= de_i ? pix_i : '0;
      cmp_valid_o <= 1'b0;
      cmp_data_o  <= '0;
    end else if (emit) begin
      pri_valid_o <= 1'b1;
      cmp_valid_o <= 1'b1;
      pri_data_o  <= odd_first_i ? odd_pix : even_q;
      cmp_data_o  <= odd_first_i ? even_q  : odd_pix;
    end else begin
      pri_valid_o <= 1'b0;
      cmp_valid_o <= 1'b0;
      if (!de_i) begin
        pri_data_o <= '0;
        cmp_data_o <= '0;
      end
    end
  end

  assert_pair_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i |=> pri_valid_o == cmp_valid_o);

  assert_pair_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_i && pri_valid_o) |=> !pri_valid_o);

  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_i && have_even_q && !de_i) |=> (pri_valid_o && cmp_valid_o));

  assert_single_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_i |=> (pri_valid_o == $past(de_i)) && !cmp_valid_o && (cmp_data_o == '0));
endmodule

// File: rtl/pix_link_splitter.sv
module pix_link_splitter
  import lsplit_pkg::*;
#(
  parameter int unsigned LANE_W = 7,
  localparam int unsigned PIX_W = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           link_mode_i,
  input  logic                 lane_swap_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  input  logic [PIX_W-1:0]     pix_i,
  output logic                 pri_valid_o,
  output logic [PIX_W-1:0]     pri_data_o,
  output logic [NUM_SLOTS-1:0] pri_ctrl_o,
  output logic                 cmp_valid_o,
  output logic [PIX_W-1:0]     cmp_data_o,
  output logic [NUM_SLOTS-1:0] cmp_ctrl_o
);
  link_mode_e       mode;
  logic             dual;
  logic             odd_first;
  logic [PIX_W-1:0] pix_routed;

  assign mode      = link_mode_e'(link_mode_i);
  assign dual      = (mode == LINK_DUAL_EVEN) || (mode == LINK_DUAL_ODD);
  assign odd_first = (mode == LINK_DUAL_ODD);

  lane_router #(.LANE_W(LANE_W)) u_lane (
    .swap_i (lane_swap_i),
    .pix_i  (pix_i),
    .pix_o  (pix_routed)
  );

  pair_splitter #(.PIX_W(PIX_W)) u_split (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dual_i      (dual),
    .odd_first_i (odd_first),
    .de_i        (de_i),
    .pix_i       (pix_routed),
    .pri_valid_o (pri_valid_o),
    .pri_data_o  (pri_data_o),
    .cmp_valid_o (cmp_valid_o),
    .cmp_data_o  (cmp_data_o)
  );

  ctrl_mapper u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dual_i     (dual),
    .hsync_i    (hsync_i),
    .vsync_i    (vsync_i),
    .de_i       (de_i),
    .pri_ctrl_o (pri_ctrl_o),
    .cmp_ctrl_o (cmp_ctrl_o)
  );

  assert_blank_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pri_valid_o && !pri_ctrl_o[SLOT_DE]) |-> pri_data_o == '0);

  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (!pri_valid_o && !cmp_valid_o && pri_data_o == '0 && cmp_data_o == '0));
endmodule

// File: tb/pix_link_splitter_tb_top.sv
module pix_link_splitter_tb_top;
  localparam int unsigned LW      = 5;
  localparam int unsigned PW      = 4 * LW;
  localparam time         CLK_PER = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    link_mode_i = 2'd0;
  logic          lane_swap_i = 1'b0;
  logic          hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [PW-1:0] pix_i = '0;
  logic          pri_valid_o, cmp_valid_o;
  logic [PW-1:0] pri_data_o, cmp_data_o;
  logic [3:0]    pri_ctrl_o, cmp_ctrl_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  pix_link_splitter #(.LANE_W(LW)) dut_i (.*);

  function automatic logic [PW-1:0] mk(input int l0, l1, l2, l3);
    return {LW'(l3), LW'(l2), LW'(l1), LW'(l0)};
  endfunction

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    de_i = 0; hsync_i = 0; vsync_i = 0; pix_i = '0;
    repeat (n) step();
  endtask

  task automatic t_reset();
    rst_ni = 0; de_i = 1; pix_i = mk(1, 2, 3, 4); link_mode_i = 2'd1;
    repeat (3) step();
    check("R10 pri_valid", 32'(pri_valid_o), 0);
    check("R10 cmp_valid", 32'(cmp_valid_o), 0);
    check("R10 pri_data", 32'(pri_data_o), 0);
    check("R10 ctrl", 32'({pri_ctrl_o, cmp_ctrl_o}), 0);
    de_i = 0; link_mode_i = 2'd0;
    rst_ni = 1;
    step();
  endtask

  task automatic t_single(input logic [1:0] m, input string tag);
    link_mode_i = m; idle(2);
    de_i = 1; pix_i = mk(1, 2, 3, 4); step();
    check({tag, " valid p0"}, 32'(pri_valid_o), 1);
    check({tag, " data p0"}, 32'(pri_data_o), 32'(mk(1, 2, 3, 4)));
    check({tag, " R2 cmp idle"}, 32'({cmp_valid_o, cmp_data_o, cmp_ctrl_o}), 0);
    pix_i = mk(5, 6, 7, 8); step();
    check({tag, " data p1"}, 32'(pri_data_o), 32'(mk(5, 6, 7, 8)));
    de_i = 0; pix_i = mk(9, 9, 9, 9); step();
    check({tag, " R9 blank valid"}, 32'(pri_valid_o), 0);
    check({tag, " R9 blank data"}, 32'(pri_data_o), 0);
  endtask

  task automatic t_dual_even();
    link_mode_i = 2'd1; idle(2);
    de_i = 1; pix_i = mk(1, 1, 1, 1); step();
    check("R3 no strobe on even", 32'({pri_valid_o, cmp_valid_o}), 0);
    pix_i = mk(2, 2, 2, 2); step();
    check("R3 both strobes", 32'({pri_valid_o, cmp_valid_o}), 3);
    check("R4 pri even", 32'(pri_data_o), 32'(mk(1, 1, 1, 1)));
    check("R4 cmp odd", 32'(cmp_data_o), 32'(mk(2, 2, 2, 2)));
    pix_i = mk(3, 3, 3, 3); step();
    check("R3 strobe single cycle", 32'({pri_valid_o, cmp_valid_o}), 0);
    check("R9 hold pri", 32'(pri_data_o), 32'(mk(1, 1, 1, 1)));
    check("R9 hold cmp", 32'(cmp_data_o), 32'(mk(2, 2, 2, 2)));
    pix_i = mk(4, 4, 4, 4); step();
    check("R4 pair2 pri", 32'(pri_data_o), 32'(mk(3, 3, 3, 3)));
    check("R4 pair2 cmp", 32'(cmp_data_o), 32'(mk(4, 4, 4, 4)));
    idle(1);
    check("R9 dual blank valid", 32'({pri_valid_o, cmp_valid_o}), 0);
    check("R9 dual blank data", 32'({pri_data_o, cmp_data_o}), 0);
  endtask

  task automatic t_dual_odd();
    link_mode_i = 2'd2; idle(2);
    de_i = 1; pix_i = mk(1, 2, 3, 4); step();
    pix_i = mk(5, 6, 7, 8); step();
    check("R5 strobes", 32'({pri_valid_o, cmp_valid_o}), 3);
    check("R5 pri odd", 32'(pri_data_o), 32'(mk(5, 6, 7, 8)));
    check("R5 cmp even", 32'(cmp_data_o), 32'(mk(1, 2, 3, 4)));
    pix_i = mk(9, 10, 11, 12); step();
    idle(1);
    check("R6 mode2 flush strobe", 32'({pri_valid_o, cmp_valid_o}), 3);
    check("R6 mode2 flush pri zero", 32'(pri_data_o), 0);
    check("R6 mode2 flush cmp even", 32'(cmp_data_o), 32'(mk(9, 10, 11, 12)));
    idle(1);
  endtask

  task automatic t_odd_line();
    link_mode_i = 2'd1; idle(2);
    de_i = 1; pix_i = mk(1, 0, 0, 0); step();
    pix_i = mk(2, 0, 0, 0); step();
    pix_i = mk(3, 0, 0, 0); step();
    check("R6 no strobe before flush", 32'(pri_valid_o), 0);
    idle(1);
    check("R6 flush strobe", 32'({pri_valid_o, cmp_valid_o}), 3);
    check("R6 flush pri even", 32'(pri_data_o), 32'(mk(3, 0, 0, 0)));
    check("R6 flush cmp zero", 32'(cmp_data_o), 0);
    check("R6 flush enable slot low", 32'(pri_ctrl_o[2]), 0);
    de_i = 1; pix_i = mk(7, 0, 0, 0); step();
    check("R3 restart no strobe", 32'(pri_valid_o), 0);
    pix_i = mk(8, 0, 0, 0); step();
    check("R3 restart pri even", 32'(pri_data_o), 32'(mk(7, 0, 0, 0)));
    check("R3 restart cmp odd", 32'(cmp_data_o), 32'(mk(8, 0, 0, 0)));
    idle(2);
  endtask

  task automatic t_lane_swap();
    lane_swap_i = 1; link_mode_i = 2'd0; idle(1);
    de_i = 1; pix_i = mk(1, 2, 3, 4); step();
    check("R8 single swapped", 32'(pri_data_o), 32'(mk(1, 4, 3, 2)));
    idle(1);
    link_mode_i = 2'd1; idle(1);
    de_i = 1; pix_i = mk(10, 11, 12, 13); step();
    pix_i = mk(20, 21, 22, 23); step();
    check("R8 dual pri swapped", 32'(pri_data_o), 32'(mk(10, 13, 12, 11)));
    check("R8 dual cmp swapped", 32'(cmp_data_o), 32'(mk(20, 23, 22, 21)));
    idle(1);
    lane_swap_i = 0; idle(1);
  endtask

  task automatic t_ctrl();
    link_mode_i = 2'd1; idle(1);
    hsync_i = 1; step();
    check("R7 hsync slot0 pri", 32'(pri_ctrl_o), 32'h1);
    check("R7 hsync slot0 cmp", 32'(cmp_ctrl_o), 32'h1);
    hsync_i = 0; vsync_i = 1; step();
    check("R7 vsync slot1", 32'(pri_ctrl_o), 32'h2);
    vsync_i = 0; de_i = 1; pix_i = mk(1, 1, 1, 1); step();
    check("R7 enable slot2", 32'({pri_ctrl_o, cmp_ctrl_o}), 32'h44);
    idle(2);
    link_mode_i = 2'd0; hsync_i = 1; vsync_i = 1; de_i = 1; step();
    check("R7 single pri slots", 32'(pri_ctrl_o), 32'h7);
    check("R7 single cmp quiet", 32'(cmp_ctrl_o), 0);
    idle(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single(2'd0, "R2 mode0");
    t_single(2'd3, "R1 mode3");
    t_dual_even();
    t_dual_odd();
    t_odd_line();
    t_lane_swap();
    t_ctrl();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule